// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog Timer

This block is a memory-mapped watchdog. A 32-bit timebase counter advances on every clock. While the watchdog is enabled, the low `INTERVAL_W` bits of that counter set the interval, and the interval expires each time those bits wrap from all ones to zero. Expiry works in two stages:

- The first expiry sets an expired flag and raises an interrupt.
- If a second expiry comes while the expired flag is still set, the block emits a system reset pulse. It also records the cause in a reset-seen flag and returns its own enables and expired flag to the off state.

Software turns the watchdog on through either of two enable bits, which sit in two different registers. To service the watchdog, software writes ones to the two write-one-to-clear flags. This also restarts the timebase from zero, so a full interval follows every service. The reset-seen flag is cleared only by power-on reset or by software, so it still shows the cause after the system reset.

Top module: `twostage_wdt`

## Requirements
- R1: After `rst_ni` is released, both control registers read zero, the timebase reads zero, and `irq_o` and `sys_rst_o` are low.
- R2: The timebase at byte offset 0x8 increases by one on every clock, whether or not the watchdog is enabled. Writes to 0x8 have no effect.
- R3: Register 0 (offset 0x0) has bit 3 = reset-seen, bit 2 = expired, bit 1 = enable A and bit 0 = enable B. Register 1 (offset 0x4) reads enable B in bit 0, and a write to it sets enable B from bit 0. A write to register 0 loads both enables from bits 1 and 0. All other bits read zero, and offset 0xC reads zero.
- R4: The watchdog is enabled when enable A or enable B is set. While both are clear, no expiry sets any flag.
- R5: The interval expires in a cycle where the watchdog is enabled and the low `INTERVAL_W` timebase bits are all ones. If the expired flag is clear at that point, the flag is set on the next edge and no reset is produced.
- R6: An expiry while the expired flag is set drives `sys_rst_o` high for exactly `RST_CYCLES` cycles, starting at the next edge. On that same edge it sets reset-seen, clears the expired flag and both enables, and zeroes the timebase.
- R7: Writing 1 to bit 3 or bit 2 of register 0 clears that flag. Writing 0 leaves the flag unchanged, and no write can set either flag.
- R8: A register 0 write with bit 2 set (a keepalive) zeroes the timebase on that edge. A keepalive in the same cycle as an expiry overrides the expiry, so no flag is set and no reset is produced.
- R9: `irq_o` is high exactly while the expired flag is set.
- R10: Reset-seen stays set through and after the `sys_rst_o` pulse, until software clears it or `rst_ni` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address; bits 3:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt level, follows the expired flag |
| sys_rst_o | output | 1 | System reset pulse on second expiry |

## Verification
The assertions assume one register write per cycle at most and a stable `addr_i`/`wdata_i` around each clock edge. They also assume that `rst_ni` is the only thing that resets the block's state, meaning `sys_rst_o` is not fed back into it. The bench drives every input half a cycle away from the active edge. It never loops `sys_rst_o` back. It forces the keepalive-versus-expiry race by polling the timebase and writing in the exact cycle of the wrap.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  // register-0 bit positions (software-visible)
  localparam int SEEN_BIT = 3;
  localparam int EXP_BIT  = 2;
  localparam int ENA_BIT  = 1;
  localparam int ENB_BIT  = 0;

  typedef enum logic [1:0] {
    REG_CTL0  = 2'd0,
    REG_CTL1  = 2'd1,
    REG_TBASE = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
module wdt_timebase #(
  parameter int INTERVAL_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       clr_i,
  output logic [wdt_pkg::DATA_W-1:0] tb_o,
  output logic                       wrap_o
);
  logic [wdt_pkg::DATA_W-1:0] tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tb_q <= '0;
    else if (clr_i) tb_q <= '0;
    else            tb_q <= tb_q + 32'd1;
  end

  assign tb_o   = tb_q;
  assign wrap_o = en_i && (&tb_q[INTERVAL_W-1:0]);

  p_tb_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> tb_q == $past(tb_q) + 32'd1);
  p_tb_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tb_q == '0);
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  reg_sel_e sel_i,
  input  logic [3:0] wdata_i,
  input  logic     wrap_i,
  output logic     seen_o,
  output logic     expired_o,
  output logic     en_a_o,
  output logic     en_b_o,
  output logic     kick_o,
  output logic     fire_o
);
  logic seen_q, exp_q, en_a_q, en_b_q;
  logic wr0, wr1, kick, fire, arm;

  assign wr0  = we_i && (sel_i == REG_CTL0);
  assign wr1  = we_i && (sel_i == REG_CTL1);
  assign kick = wr0 && wdata_i[EXP_BIT];
  // keepalive in the same cycle overrides either expiry stage
  assign fire = wrap_i && exp_q && !kick;
  assign arm  = wrap_i && !exp_q && !kick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      exp_q  <= 1'b0;
      en_a_q <= 1'b0;
      en_b_q <= 1'b0;
    end else if (fire) begin
      seen_q <= 1'b1;
      exp_q  <= 1'b0;
      en_a_q <= 1'b0;
      en_b_q <= 1'b0;
    end else begin
      if (wr0 && wdata_i[SEEN_BIT]) seen_q <= 1'b0;
      if (arm)       exp_q <= 1'b1;
      else if (kick) exp_q <= 1'b0;
      if (wr0) begin
        en_a_q <= wdata_i[ENA_BIT];
        en_b_q <= wdata_i[ENB_BIT];
      end else if (wr1) begin
        en_b_q <= wdata_i[ENB_BIT];
      end
    end
  end

  assign seen_o    = seen_q;
  assign expired_o = exp_q;
  assign en_a_o    = en_a_q;
  assign en_b_o    = en_b_q;
  assign kick_o    = kick;
  assign fire_o    = fire;

  p_disabled_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_a_q || en_b_q) |=> !$rose(exp_q));
  p_first_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !exp_q && !kick) |=> (exp_q && !seen_q == !$past(seen_q)));
  p_second_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && exp_q && !kick) |=> (seen_q && !exp_q && !en_a_q && !en_b_q));
  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && wdata_i[SEEN_BIT] && !fire) |=> !seen_q);
  p_seen_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !wr0) |=> seen_q);
endmodule

// File: rtl/wdt_rst_pulse.sv
`timescale 1ns/1ps
module wdt_rst_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  p_pulse_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> pulse_o);
  p_pulse_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/twostage_wdt.sv
`timescale 1ns/1ps
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int INTERVAL_W = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] tb;
  logic              wrap, seen, expired, en_a, en_b, kick, fire;
  logic              unused_bits;

  assign sel         = reg_sel_e'(addr_i[3:2]);
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:4]};

  wdt_timebase #(.INTERVAL_W(INTERVAL_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_a || en_b),
    .clr_i  (kick || fire),
    .tb_o   (tb),
    .wrap_o (wrap)
  );

  wdt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i[3:0]),
    .wrap_i    (wrap),
    .seen_o    (seen),
    .expired_o (expired),
    .en_a_o    (en_a),
    .en_b_o    (en_b),
    .kick_o    (kick),
    .fire_o    (fire)
  );

  wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (fire),
    .pulse_o (sys_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_CTL0:  rdata_o = {28'd0, seen, expired, en_a, en_b};
      REG_CTL1:  rdata_o = {31'd0, en_b};
      REG_TBASE: rdata_o = tb;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = expired;

  initial begin
    assert (INTERVAL_W >= 8 && INTERVAL_W <= 31);
    assert (RST_CYCLES >= 1);
  end

  p_irq_no_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$rose(sys_rst_o));
  p_rst_clears_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> !irq_o);
endmodule

// File: tb/twostage_wdt_tb.sv
`timescale 1ns/1ps
module twostage_wdt_tb;
  localparam int N  = 8;
  localparam int RC = 4;
  localparam logic [31:0] MASK = (32'd1 << N) - 32'd1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = 4'd0;
  logic [31:0] wdata_i = 32'd0;
  logic [31:0] rdata_o;
  logic        irq_o, sys_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;

  twostage_wdt #(.INTERVAL_W(N), .RST_CYCLES(RC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  always #2.5 clk_i = ~clk_i;

  // behavioural reference
  logic [31:0] m_tb;
  bit m_seen, m_exp, m_ea, m_eb;
  int m_cnt;
  bit s_w0, s_w1, s_kick, s_wrap, s_fire;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tb = 0; m_seen = 0; m_exp = 0; m_ea = 0; m_eb = 0; m_cnt = 0;
    end else begin
      s_w0   = we_i && addr_i[3:2] == 2'd0;
      s_w1   = we_i && addr_i[3:2] == 2'd1;
      s_kick = s_w0 && wdata_i[2];
      s_wrap = (m_ea || m_eb) && ((m_tb & MASK) == MASK);
      s_fire = s_wrap && m_exp && !s_kick;
      if (s_fire) m_cnt = RC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (s_fire) begin
        m_seen = 1; m_exp = 0; m_ea = 0; m_eb = 0;
      end else begin
        if (s_w0 && wdata_i[3]) m_seen = 0;
        if (s_kick) m_exp = 0;
        else if (s_wrap) m_exp = 1;
        if (s_w0) begin m_ea = wdata_i[1]; m_eb = wdata_i[0]; end
        else if (s_w1) m_eb = wdata_i[0];
      end
      m_tb = (s_kick || s_fire) ? 32'd0 : m_tb + 32'd1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] idx);
    case (idx)
      2'd0:    return {28'd0, m_seen, m_exp, m_ea, m_eb};
      2'd1:    return {31'd0, m_eb};
      2'd2:    return m_tb;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk_i) begin
    if (live) begin
      check("R9 irq", {31'd0, irq_o}, {31'd0, m_exp});
      check("R6 sys_rst", {31'd0, sys_rst_o}, {31'd0, m_cnt > 0});
      check(addr_i[3:2] == 2'd2 ? "R2 rdata" : "R3 rdata", rdata_o, exp_rd(addr_i[3:2]));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); #1;
    we_i = 1'b0; wdata_i = 32'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i); #1;
    addr_i = a; #1;
    d = rdata_o;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int hi;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    live = 1'b1;
    // R1 reset state
    rd(4'h0, v); check("R1 ctl0", v, 32'd0);
    rd(4'h4, v); check("R1 ctl1", v, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 sys_rst", {31'd0, sys_rst_o}, 32'd0);
    // R2 timebase advances, write ignored
    rd(4'h8, v); rd(4'h8, v2); check("R2 step", v2, v + 32'd1);
    wr(4'h8, 32'd0); rd(4'h8, v); check("R2 write ignored", v, exp_rd(2'd2));
    check("R2 nonzero after write", {31'd0, v > 32'd3}, 32'd1);
    // R3 layout
    wr(4'h4, 32'hFFFF_FFF1); rd(4'h0, v); check("R3 ctl1 sets enable B", v, 32'h1);
    rd(4'h4, v); check("R3 ctl1 read", v, 32'h1);
    wr(4'h0, 32'h0000_0002); rd(4'h0, v); check("R3 ctl0 loads both enables", v, 32'h2);
    rd(4'h4, v); check("R3 ctl1 follows enable B", v, 32'h0);
    rd(4'hC, v); check("R3 unmapped reads zero", v, 32'h0);
    // R4 disabled: no flags for more than two intervals
    wr(4'h0, 32'h0);
    repeat (700) @(negedge clk_i);
    rd(4'h0, v); check("R4 disabled no flags", v, 32'h0);
    // R5 first expiry -> irq only
    wr(4'h0, 32'h0000_000E);
    while (!irq_o) @(negedge clk_i);
    check("R5 irq set", {31'd0, irq_o}, 32'd1);
    check("R5 no reset", {31'd0, sys_rst_o}, 32'd0);
    rd(4'h0, v); check("R5 expired flag", v, 32'h6);
    // R7 write 0 keeps flag, write 1 clears
    wr(4'h0, 32'h0000_0002); rd(4'h0, v); check("R7 zero write keeps flag", v, 32'h6);
    wr(4'h0, 32'h0000_000E); rd(4'h0, v); check("R7 w1c clears", v, 32'h2);
    check("R9 irq low after clear", {31'd0, irq_o}, 32'd0);
    rd(4'h8, v); check("R8 timebase restarted", {31'd0, v < 32'd8}, 32'd1);
    // R6 second expiry -> reset pulse
    while (!sys_rst_o) @(negedge clk_i);
    hi = 0;
    while (sys_rst_o) begin hi++; @(negedge clk_i); end
    check("R6 pulse length", hi, RC);
    rd(4'h0, v); check("R6 state after reset", v, 32'h8);
    // R10 reset-seen sticky, R7 clear
    repeat (20) @(negedge clk_i);
    rd(4'h0, v); check("R10 seen survives", v, 32'h8);
    wr(4'h0, 32'h0); rd(4'h0, v); check("R7 zero write keeps seen", v, 32'h8);
    wr(4'h0, 32'h8); rd(4'h0, v); check("R7 seen cleared", v, 32'h0);
    // R8 keepalive in the cycle of the second expiry wins
    wr(4'h4, 32'h1);
    wr(4'h0, 32'h5);
    while (!irq_o) @(negedge clk_i);
    v = 32'd0;
    while ((v & MASK) != (MASK - 32'd1)) rd(4'h8, v);
    wr(4'h0, 32'h5);
    repeat (RC + 2) begin
      @(negedge clk_i);
      check("R8 no reset on race", {31'd0, sys_rst_o}, 32'd0);
    end
    rd(4'h0, v); check("R8 enables kept, flag cleared", v, 32'h1);
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule